// File: doc/BRIEF.md
# Dual-Channel Pulse-Width Modulator

This block drives two pulse-width modulated pins from one clock. Each pin has its own period count (range), on-count (data) and control byte. The two control bytes sit side by side in one 16-bit control register. In contiguous mode, a period is one block of high clocks followed by low clocks. In spread mode, an accumulator spaces the high clocks as evenly as it can across the period. Both modes give exactly `data` high clocks in each period of `range` clocks.

Software reaches the block through a plain read/write port: an address, a write strobe, write data and combinational read data. A new range or data value waits in a shadow register and is adopted only at the next period boundary, so a period never mixes two settings. A disabled channel holds its pin at the channel's idle level. The control bits for serial output, repeat-last and queued data are kept and read back, but they change nothing in the output.

Top module: `duo_pwm`

## Requirements
- R1: After reset, both pins are 0 and every register reads 0.
- R2: The control register is at address 0x00. Channel 0 range and data are at 0x10 and 0x14, and channel 1 range and data are at 0x20 and 0x24. Each of these reads back the last value written. Any other address reads 0 and ignores writes.
- R3: Control bits 6 and 14 are not stored and always read 0. Writing 0xFFFF reads back 0xBFBF.
- R4: Channel n uses control byte n, held in bits 8n+7..8n. Bit 0 of the byte is enable and bit 7 selects contiguous mode. The first clock edge after the edge that writes enable=1 outputs period position 0. From then on, the pin is high for positions 0..data-1 of each period and low for the rest.
- R5: With byte bit 7 = 0, the channel outputs spread mode. At period position p it is high exactly when floor((p+1)·data/range) > floor(p·data/range). This gives `data` high clocks per period.
- R6: If data ≥ range and range > 0, the pin is constantly active. If range = 0, the pin holds the idle level.
- R7: Byte bit 4 inverts the active output.
- R8: Byte bit 3 is the idle level. When enable is 0, the pin takes that level, without inversion, on the next edge.
- R9: A range or data write made mid-period takes effect from the next period boundary. The rest of the current period uses the old values.
- R10: Clearing enable forces the idle level on the next edge. A later enable restarts the pattern at position 0.
- R11: The channels run independently. Writing 0 to the control register disables both.
- R12: Byte bits 1, 2 and 5 are stored and read back but do not affect the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | PWM and register clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | AW | Register address |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data for `addr`, combinational |
| pwm_out | output | 2 | Registered pin levels, bit n for channel n |

## Verification
The checks on idle level and full-on output assume that a control write reaches the pins only after a full clock edge. They also assume that the pin reflects the state one edge earlier. The stimulus therefore changes inputs only on falling edges and holds each write strobe for exactly one rising edge. The bound on the period counter assumes that a range change reaches the counter only at a boundary. To stay within that, the bench makes its mid-period data write away from any boundary. It also leaves out the cycle that carries the write when it compares pin levels.

// File: rtl/duo_pwm.sv
module duo_pwm #(
  parameter int W  = 16,
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic [1:0]    pwm_out
);
  localparam logic [AW-1:0] A_CTL  = AW'(8'h00);
  localparam logic [AW-1:0] A_RNG0 = AW'(8'h10);
  localparam logic [AW-1:0] A_DAT0 = AW'(8'h14);
  localparam logic [AW-1:0] A_RNG1 = AW'(8'h20);
  localparam logic [AW-1:0] A_DAT1 = AW'(8'h24);
  localparam logic [15:0]   CTL_KEEP = 16'hBFBF;

  logic [15:0]         ctl_q;
  logic [1:0][W-1:0]   rng_s, dat_s, rng_a, dat_a, cnt, acc;
  logic [1:0][W-1:0]   er, ed, acc_n, cnt_n;
  logic [1:0][W:0]     sum;
  logic [1:0]          run, bnd, hit, pin_n;

  always_comb begin
    for (int i = 0; i < 2; i++) begin
      bnd[i]   = !run[i] || (cnt[i] == '0);
      er[i]    = bnd[i] ? rng_s[i] : rng_a[i];
      ed[i]    = bnd[i] ? dat_s[i] : dat_a[i];
      sum[i]   = (bnd[i] ? {(W+1){1'b0}} : {1'b0, acc[i]}) + {1'b0, ed[i]};
      hit[i]   = 1'b0;
      acc_n[i] = '0;
      if (ed[i] >= er[i]) begin
        hit[i] = 1'b1;
      end else if (ctl_q[8*i+7]) begin
        hit[i] = cnt[i] < ed[i];
      end else if (sum[i] >= {1'b0, er[i]}) begin
        hit[i]   = 1'b1;
        acc_n[i] = W'(sum[i] - {1'b0, er[i]});
      end else begin
        acc_n[i] = sum[i][W-1:0];
      end
      cnt_n[i] = (er[i] == '0 || cnt[i] == er[i] - 1'b1) ? '0 : cnt[i] + 1'b1;
      pin_n[i] = (ctl_q[8*i] && er[i] != '0) ? (hit[i] ^ ctl_q[8*i+4]) : ctl_q[8*i+3];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q   <= '0;
      rng_s   <= '0;
      dat_s   <= '0;
      rng_a   <= '0;
      dat_a   <= '0;
      cnt     <= '0;
      acc     <= '0;
      run     <= '0;
      pwm_out <= '0;
    end else begin
      if (wr_en) begin
        case (addr)
          A_CTL:   ctl_q    <= wdata[15:0] & CTL_KEEP;
          A_RNG0:  rng_s[0] <= wdata[W-1:0];
          A_DAT0:  dat_s[0] <= wdata[W-1:0];
          A_RNG1:  rng_s[1] <= wdata[W-1:0];
          A_DAT1:  dat_s[1] <= wdata[W-1:0];
          default: ;
        endcase
      end
      for (int i = 0; i < 2; i++) begin
        if (!ctl_q[8*i]) begin
          run[i] <= 1'b0;
          cnt[i] <= '0;
          acc[i] <= '0;
        end else begin
          run[i]   <= 1'b1;
          rng_a[i] <= er[i];
          dat_a[i] <= ed[i];
          cnt[i]   <= cnt_n[i];
          acc[i]   <= acc_n[i];
        end
      end
      pwm_out <= pin_n;
    end
  end

  always_comb begin
    case (addr)
      A_CTL:   rdata = DW'(ctl_q);
      A_RNG0:  rdata = DW'(rng_s[0]);
      A_DAT0:  rdata = DW'(dat_s[0]);
      A_RNG1:  rdata = DW'(rng_s[1]);
      A_DAT1:  rdata = DW'(dat_s[1]);
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/duo_pwm_chk.sv
module duo_pwm_chk #(
  parameter int W  = 16,
  parameter int AW = 8,
  parameter int DW = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [AW-1:0]     addr,
  input logic [DW-1:0]     rdata,
  input logic [15:0]       ctl,
  input logic [1:0]        run,
  input logic [1:0][W-1:0] cnt,
  input logic [1:0][W-1:0] rng_a,
  input logic [1:0][W-1:0] dat_a,
  input logic [1:0]        pin
);
  a_r8_idle_silence0: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl[0] |=> pin[0] == $past(ctl[3]));

  a_r8_idle_silence1: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl[8] |=> pin[1] == $past(ctl[11]));

  a_r3_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == '0) |-> (rdata[6] == 1'b0 && rdata[14] == 1'b0));

  a_r6_full_high: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl[0] && run[0] && cnt[0] != '0 && rng_a[0] != '0 && dat_a[0] >= rng_a[0])
    |=> pin[0] == !$past(ctl[4]));

  a_r9_count_bound0: assert property (@(posedge clk) disable iff (!rst_n)
    (run[0] && rng_a[0] != '0) |-> cnt[0] < rng_a[0]);

  a_r9_count_bound1: assert property (@(posedge clk) disable iff (!rst_n)
    (run[1] && rng_a[1] != '0) |-> cnt[1] < rng_a[1]);
endmodule

bind duo_pwm duo_pwm_chk #(.W(W), .AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .rdata(rdata), .ctl(ctl_q),
  .run(run), .cnt(cnt), .rng_a(rng_a), .dat_a(dat_a), .pin(pwm_out)
);

// File: tb/duo_pwm_test.sv
`timescale 1ns/1ps
module duo_pwm_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [1:0]  pwm_out;

  duo_pwm uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
    .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out)
  );

  always #2.5 clk = ~clk;

  int vecs = 0;
  int errs = 0;
  logic [1:0] eq[$];
  string      tq[$];

  int cd[2];
  int cr[2];
  bit cms[2], cpol[2], csil[2], cen[2];

  function automatic logic expv(int ch, int k);
    int p;
    logic b;
    if (!cen[ch] || cr[ch] == 0) return csil[ch];
    p = k % cr[ch];
    if (cd[ch] >= cr[ch]) b = 1'b1;
    else if (cms[ch]) b = (p < cd[ch]);
    else b = (((p + 1) * cd[ch]) / cr[ch]) > ((p * cd[ch]) / cr[ch]);
    return b ^ cpol[ch];
  endfunction

  function automatic logic [15:0] ctlw();
    logic [15:0] w;
    w = '0;
    for (int c = 0; c < 2; c++)
      w[8*c +: 8] = {cms[c], 2'b00, cpol[c], csil[c], 2'b00, cen[c]};
    return w;
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rdchk(input logic [7:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    addr = a;
    #1;
    vecs++;
    if (rdata !== e) begin
      errs++;
      $display("FAIL %s: read addr %h got %h expected %h", tag, a, rdata, e);
    end
  endtask

  task automatic run(input int n, input int k0, input string tag);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      eq.push_back({expv(1, k0 + k), expv(0, k0 + k)});
      tq.push_back(tag);
    end
  endtask

  task automatic cfg(input int c, input bit en, input bit ms, input bit pol,
                     input bit sil, input int d, input int r);
    cen[c] = en; cms[c] = ms; cpol[c] = pol; csil[c] = sil; cd[c] = d; cr[c] = r;
  endtask

  always @(negedge clk) begin
    if (eq.size() > 0) begin
      logic [1:0] e;
      string t;
      e = eq.pop_front();
      t = tq.pop_front();
      vecs++;
      if (pwm_out !== e) begin
        errs++;
        $display("FAIL %s: pwm_out got %b expected %b", t, pwm_out, e);
      end
    end
  end

  initial begin
    #100000;
    errs++;
    $display("FAIL watchdog: run did not finish, got hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    cfg(0, 0, 0, 0, 0, 0, 0);
    cfg(1, 0, 0, 0, 0, 0, 0);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    vecs++;
    if (pwm_out !== 2'b00) begin
      errs++;
      $display("FAIL R1: pwm_out got %b expected 00", pwm_out);
    end
    rdchk(8'h00, 0, "R1"); rdchk(8'h10, 0, "R1"); rdchk(8'h14, 0, "R1");
    rdchk(8'h20, 0, "R1"); rdchk(8'h24, 0, "R1");

    wr(8'h10, 8); wr(8'h14, 3); wr(8'h20, 8); wr(8'h24, 3);
    wr(8'h30, 32'h55);
    rdchk(8'h10, 8, "R2"); rdchk(8'h14, 3, "R2");
    rdchk(8'h20, 8, "R2"); rdchk(8'h24, 3, "R2");
    rdchk(8'h30, 0, "R2"); rdchk(8'h08, 0, "R2");

    wr(8'h00, 32'hFFFF);
    rdchk(8'h00, 32'hBFBF, "R3");
    wr(8'h00, 0);

    // R4 contiguous on channel 0; R8 idle level 1 on disabled channel 1
    cfg(0, 1, 1, 0, 0, 3, 8);
    cfg(1, 0, 0, 0, 1, 3, 8);
    wr(8'h00, {16'h0, ctlw()});
    run(11, 0, "R4");

    // R10 disable then restart at position 0
    cen[0] = 0;
    wr(8'h00, {16'h0, ctlw()});
    run(2, 0, "R10");
    cen[0] = 1;
    wr(8'h00, {16'h0, ctlw()});
    run(10, 0, "R10");

    // R11 zero control disables both
    wr(8'h00, 0);
    cfg(0, 0, 0, 0, 0, 3, 8);
    cfg(1, 0, 0, 0, 0, 3, 8);
    run(3, 0, "R11");

    // R5 spread mode on both channels at once
    wr(8'h10, 7); wr(8'h14, 5);
    cfg(0, 1, 0, 0, 0, 5, 7);
    cfg(1, 1, 0, 0, 0, 3, 8);
    wr(8'h00, {16'h0, ctlw()});
    run(16, 0, "R5");

    // R7 inversion
    wr(8'h00, 0);
    wr(8'h10, 8); wr(8'h14, 3);
    cfg(0, 1, 1, 1, 0, 3, 8);
    cfg(1, 0, 0, 0, 0, 3, 8);
    wr(8'h00, {16'h0, ctlw()});
    run(12, 0, "R7");

    // R6 full-on channel 0, zero range channel 1 (idle 0 despite inversion)
    wr(8'h00, 0);
    wr(8'h14, 9); wr(8'h20, 0);
    cfg(0, 1, 1, 0, 0, 9, 8);
    cfg(1, 1, 1, 1, 0, 3, 0);
    wr(8'h00, {16'h0, ctlw()});
    run(12, 0, "R6");

    // R9 mid-period data change
    wr(8'h00, 0);
    wr(8'h10, 5); wr(8'h14, 2);
    cfg(0, 1, 1, 0, 0, 2, 5);
    cfg(1, 0, 0, 0, 0, 3, 0);
    wr(8'h00, {16'h0, ctlw()});
    run(3, 0, "R9");
    wr(8'h14, 4);
    run(1, 4, "R9");
    cd[0] = 4;
    run(5, 5, "R9");

    // R12 serial, repeat and queue bits stored without effect
    wr(8'h00, 0);
    wr(8'h10, 8); wr(8'h14, 3);
    cfg(0, 1, 1, 0, 0, 3, 8);
    wr(8'h00, 32'h00A7);
    run(10, 0, "R12");
    rdchk(8'h00, 32'h00A7, "R12");

    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule